// File: doc/BRIEF.md
# Panel Scan Timing Generator

This block produces the row-and-column timing for a 1/240-duty passive matrix panel. In master mode it divides the oscillator clock. Each strobe lasts two oscillator periods. A half frame holds 121 strobes and a full frame holds 242 strobes, or 484 clocks. The block emits an active-low frame pulse at the start of each half frame. It also drives two level-select lines that tell the row driver which drive level to apply. The level-select lines follow a fixed 16-step sequence that advances once per strobe.

In slave mode the block generates no timing of its own. It samples a strobe and a frame pulse from the bus and advances the level-select sequence from those inputs.

After every reset the block holds its display-off output active for four frames. It then passes the external display-off request straight through.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `rst_n` is low, `stb_out` = 0, `frm_n_out` = 1, `lvl1` = 1, `lvl2` = 1 and `disp_off` = 1.
- R2: In master mode the first strobe starts one clock after reset is released. From then on `stb_out` is high for one clock and low for the next, so one strobe spans 2 clocks.
- R3: In master mode, strobes are numbered from 0 after reset. Strobe s lies in half-frame slot s mod 121. `frm_n_out` is low for both clocks of every strobe in slot 0 and high otherwise, which gives two frame pulses per 484 clocks.
- R4: The step index k is the number of strobes completed since reset, modulo 16. It changes at the clock edge that closes a strobe. `lvl1` = 1 for k = 0..7 and 0 for k = 8..15.
- R5: `lvl2` follows 1,0,1,0 for k = 0..3, then 0,1,0,1 for k = 4..7, then 0,1,0,1 for k = 8..11, then 1,0,1,0 for k = 12..15.
- R6: After reset, `disp_off` stays 1 until eight half-frame boundaries have passed. In master mode that is the first 1 + 8*242 clocks after release, which is four frames. After that `disp_off` equals `doff_req`.
- R7: `disp_off` = 1 in any cycle in which `doff_req` = 1, with no clock delay.
- R8: With `master_sel` = 0, `stb_out` stays 0 and `frm_n_out` stays 1.
- R9: With `master_sel` = 0, the step index advances at each clock edge that samples `stb_in` = 0 when the previous edge sampled `stb_in` = 1.
- R10: With `master_sel` = 0, blanking ends at the eighth clock edge after reset that samples `frm_n_in` = 0 when the previous edge sampled 1.
- R11: Asserting reset in mid-operation returns all outputs to the R1 values. After release the full four-frame blanking period runs again and the timing restarts at strobe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; one strobe is two periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = generate timing, 0 = follow the bus inputs |
| doff_req | input | 1 | External display-off request, active high |
| stb_in | input | 1 | Strobe sampled in slave mode |
| frm_n_in | input | 1 | Active-low frame pulse sampled in slave mode |
| stb_out | output | 1 | Generated column strobe |
| frm_n_out | output | 1 | Generated active-low frame pulse |
| lvl1 | output | 1 | Row level select, first line |
| lvl2 | output | 1 | Row level select, second line |
| disp_off | output | 1 | Combined display-off, active high |

## Verification
In master mode, the clock edge that ends the post-reset blanking is also the edge that starts a new half frame. On that edge `disp_off` falls, `frm_n_out` falls and the step index advances, all together. The bench sweeps every clock through several frames and compares each output against values computed from the clock count. This pins down that coincident cycle exactly. It also switches `doff_req` both inside and after the blanking window, so an off-by-one in the blanking count shows up as a miscompare.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    localparam int STEP_W = 4;

    typedef enum logic [1:0] {
        STB_IDLE = 2'd0,
        STB_HIGH = 2'd1,
        STB_LOW  = 2'd2
    } stb_state_e;

    typedef enum logic {
        BLK_HOLD = 1'b0,
        BLK_SHOW = 1'b1
    } blank_state_e;

    function automatic logic level_one(input logic [STEP_W-1:0] k);
        return ~k[STEP_W-1];
    endfunction

    function automatic logic level_two(input logic [STEP_W-1:0] k);
        return ~k[0] ^ k[3] ^ k[2];
    endfunction

endpackage

// File: rtl/lcdt_strobe_gen.sv
module lcdt_strobe_gen
    import lcdt_pkg::*;
#(
    parameter int HALF_STROBES = 121
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_i,
    output logic stb_o,
    output logic frm_n_o,
    output logic strobe_done_o,
    output logic half_done_o
);
    localparam int CNT_W = $clog2(HALF_STROBES);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(HALF_STROBES - 1);

    stb_state_e state_q, state_d;
    logic [CNT_W-1:0] slot_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STB_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STB_IDLE: state_d = master_i ? STB_HIGH : STB_IDLE;
            STB_HIGH: state_d = master_i ? STB_LOW  : STB_IDLE;
            STB_LOW:  state_d = master_i ? STB_HIGH : STB_IDLE;
            default:  state_d = STB_IDLE;
        endcase
    end

    // slot within the half frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_q <= '0;
        else if (!master_i)
            slot_q <= '0;
        else if (state_q == STB_LOW)
            slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
    end

    // outputs
    always_comb begin
        stb_o         = master_i && (state_q == STB_HIGH);
        frm_n_o       = !(master_i && (state_q != STB_IDLE) && (slot_q == '0));
        strobe_done_o = master_i && (state_q == STB_LOW);
        half_done_o   = master_i && (state_q == STB_LOW) && (slot_q == LAST_SLOT);
    end

endmodule

// File: rtl/lcdt_row_level.sv
module lcdt_row_level
    import lcdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic l1_o,
    output logic l2_o
);
    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     step_q <= '0;
        else if (adv_i) step_q <= step_q + 1'b1;
    end

    always_comb begin
        l1_o = level_one(step_q);
        l2_o = level_two(step_q);
    end

endmodule

// File: rtl/lcdt_blanker.sv
module lcdt_blanker
    import lcdt_pkg::*;
#(
    parameter int EVENTS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic req_i,
    output logic off_o
);
    localparam int CNT_W = $clog2(EVENTS + 1);
    localparam logic [CNT_W-1:0] LAST_EVT = CNT_W'(EVENTS - 1);

    blank_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BLK_HOLD;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BLK_HOLD: if (tick_i && cnt_q == LAST_EVT) state_d = BLK_SHOW;
            BLK_SHOW: state_d = BLK_SHOW;
            default:  state_d = BLK_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q == BLK_HOLD && tick_i)
            cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb off_o = req_i || (state_q == BLK_HOLD);

endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcdt_pkg::*;
#(
    parameter int HALF_STROBES = 121,
    parameter int BLANK_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_sel,
    input  logic doff_req,
    input  logic stb_in,
    input  logic frm_n_in,
    output logic stb_out,
    output logic frm_n_out,
    output logic lvl1,
    output logic lvl2,
    output logic disp_off
);
    localparam int BLANK_EVENTS = 2 * BLANK_FRAMES;

    logic strobe_done, half_done;
    logic stb_prev_q, frm_prev_q;
    logic slave_stb_fall, slave_frm_fall;
    logic adv, tick;

    lcdt_strobe_gen #(.HALF_STROBES(HALF_STROBES)) u_strobe (
        .clk          (clk),
        .rst_n        (rst_n),
        .master_i     (master_sel),
        .stb_o        (stb_out),
        .frm_n_o      (frm_n_out),
        .strobe_done_o(strobe_done),
        .half_done_o  (half_done)
    );

    // bus input edge sampling for slave mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_prev_q <= 1'b0;
            frm_prev_q <= 1'b1;
        end else begin
            stb_prev_q <= stb_in;
            frm_prev_q <= frm_n_in;
        end
    end

    always_comb begin
        slave_stb_fall = !master_sel && stb_prev_q && !stb_in;
        slave_frm_fall = !master_sel && frm_prev_q && !frm_n_in;
        adv            = master_sel ? strobe_done : slave_stb_fall;
        tick           = master_sel ? half_done   : slave_frm_fall;
    end

    lcdt_row_level u_level (
        .clk  (clk),
        .rst_n(rst_n),
        .adv_i(adv),
        .l1_o (lvl1),
        .l2_o (lvl2)
    );

    lcdt_blanker #(.EVENTS(BLANK_EVENTS)) u_blank (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick),
        .req_i (doff_req),
        .off_o (disp_off)
    );

endmodule

// File: rtl/lcd_scan_timer_checker.sv
module lcd_scan_timer_checker (
    input logic clk,
    input logic rst_n,
    input logic master_sel,
    input logic doff_req,
    input logic stb_out,
    input logic frm_n_out,
    input logic lvl1,
    input logic lvl2,
    input logic disp_off
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && stb_out) |=> !stb_out); // R2

    AST_STB_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !stb_out && $past(stb_out)) |=> (stb_out || !master_sel)); // R2

    AST_FRAME_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frm_n_out) |-> stb_out); // R3

    AST_FRAME_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frm_n_out) |=> (!frm_n_out || !master_sel)); // R3

    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && !stb_out && $past(stb_out)) |-> ($stable(lvl1) && $stable(lvl2))); // R4

    AST_BLANK_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!doff_req && !disp_off) |=> (!disp_off || doff_req)); // R6

    AST_DOFF_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        doff_req |-> disp_off); // R7

    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (!stb_out && frm_n_out)); // R8

endmodule

bind lcd_scan_timer lcd_scan_timer_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .master_sel(master_sel),
    .doff_req  (doff_req),
    .stb_out   (stb_out),
    .frm_n_out (frm_n_out),
    .lvl1      (lvl1),
    .lvl2      (lvl2),
    .disp_off  (disp_off)
);

// File: tb/lcd_scan_timer_bench.sv
`timescale 1ns/1ps
module lcd_scan_timer_bench;
    logic clk = 1'b0;
    logic rst_n, master_sel, doff_req, stb_in, frm_n_in;
    logic stb_out, frm_n_out, lvl1, lvl2, disp_off;
    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    lcd_scan_timer u_lcd_scan_timer (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .doff_req(doff_req),
        .stb_in(stb_in), .frm_n_in(frm_n_in), .stb_out(stb_out),
        .frm_n_out(frm_n_out), .lvl1(lvl1), .lvl2(lvl2), .disp_off(disp_off)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp, input int t);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, t, act, exp);
        end
    endtask

    function automatic logic exp_l1(input int k);
        return k < 8;
    endfunction

    function automatic logic exp_l2(input int k);
        logic base;
        base = (k % 2) == 0;
        return base ^ (((k / 4) == 1) || ((k / 4) == 2));
    endfunction

    task automatic check_reset_state(input string req);
        chk(req, "stb_out", stb_out, 1'b0, 0);
        chk(req, "frm_n_out", frm_n_out, 1'b1, 0);
        chk(req, "lvl1", lvl1, 1'b1, 0);
        chk(req, "lvl2", lvl2, 1'b1, 0);
        chk(req, "disp_off", disp_off, 1'b1, 0);
    endtask

    // called at a falling edge with reset just released
    task automatic run_master(input int n, input bit again);
        for (int t = 0; t < n; t++) begin
            logic e_stb, e_frm, e_blank;
            int u, s, k;
            doff_req = (t >= 1000 && t < 1010) || (t >= 2600 && t < 2800 && (t % 7) < 3);
            #1;
            if (t == 0) begin
                e_stb = 1'b0; e_frm = 1'b1; k = 0;
            end else begin
                u = t - 1;
                s = u / 2;
                e_stb = (u % 2) == 0;
                e_frm = (s % 121) != 0;
                k = s % 16;
            end
            e_blank = t < (1 + 8 * 242);
            chk("R2", "stb_out", stb_out, e_stb, t);
            chk("R3", "frm_n_out", frm_n_out, e_frm, t);
            chk("R4", "lvl1", lvl1, exp_l1(k), t);
            chk("R5", "lvl2", lvl2, exp_l2(k), t);
            if (again)
                chk("R11", "disp_off", disp_off, e_blank || doff_req, t);
            else if (doff_req)
                chk("R7", "disp_off", disp_off, 1'b1, t);
            else
                chk("R6", "disp_off", disp_off, e_blank, t);
            @(negedge clk);
        end
    endtask

    task automatic run_slave(input int n);
        logic m_pstb = 1'b0;
        logic m_pfrm = 1'b1;
        int m_step = 0;
        int m_falls = 0;
        for (int t = 0; t < n; t++) begin
            stb_in   = (t < 250) ? ((t % 5) < 2) : ((t % 3) == 0);
            frm_n_in = !((t % 37) == 5);
            doff_req = (t > 300) && ((t % 53) > 48);
            #1;
            chk("R8", "stb_out", stb_out, 1'b0, t);
            chk("R8", "frm_n_out", frm_n_out, 1'b1, t);
            chk("R9", "lvl1", lvl1, exp_l1(m_step % 16), t);
            chk("R9", "lvl2", lvl2, exp_l2(m_step % 16), t);
            chk("R10", "disp_off", disp_off, (m_falls < 8) || doff_req, t);
            if (m_pstb && !stb_in) m_step++;
            if (m_pfrm && !frm_n_in) m_falls++;
            m_pstb = stb_in;
            m_pfrm = frm_n_in;
            @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0; master_sel = 1'b1; doff_req = 1'b0; stb_in = 1'b0; frm_n_in = 1'b1;
        repeat (3) @(negedge clk);
        #1 check_reset_state("R1");
        @(negedge clk);
        rst_n = 1'b1;
        run_master(3400, 1'b0);
        rst_n = 1'b0;
        doff_req = 1'b0;
        #1 check_reset_state("R11");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_master(600, 1'b1);
        rst_n = 1'b0;
        master_sel = 1'b0;
        doff_req = 1'b0;
        #1 check_reset_state("R1");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run_slave(500);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule